// File: doc/BRIEF.md
# Wide Control Register Bank with High-Half Aliases

This block holds four 64-bit control registers behind a single control-register access port whose data path is `XLEN` bits wide, with `XLEN` set to 32 or 64. Each access carries a 12-bit address, an operation, write data, the current privilege level and the virtualization bit. One cycle later the block returns read data or one of two exception flags: illegal-instruction or virtual-instruction.

The full 64-bit state is always kept. When `XLEN=32`, every register has a second, high-half address that reaches bits 63:32. When `XLEN=64`, the high-half addresses are reserved and every access to them faults.

Accesses that fail the privilege check are classified for a trap unit. For a guest access (virtualization bit set) to a register that a hypervisor-level host could legally reach, the block raises virtual-instruction. For every other bad access it raises illegal-instruction.

The register set, with low and high addresses and minimum level:

- machine environment control: 0x30A / 0x31A, level M
- security control: 0x747 / 0x757, level M
- hypervisor environment control: 0x60A / 0x61A, level S
- guest time offset: 0x605 / 0x615, level S

Top module: `csr_wide_bank`

## Requirements
- R1: A read at a low address returns bits XLEN-1:0 of the register. Any access returns the value held before that access. `rspValid` and the result appear on the cycle after `accValid`.
- R2: With XLEN=32, a write at a low address changes only bits 31:0, and bits 63:32 keep their old value. With XLEN=64, a low write replaces all 64 bits.
- R3: With XLEN=32, a high address reads bits 63:32 in the low 32 bits of `rspRdata`, and a write there changes only bits 63:32.
- R4: With XLEN=64, any access to a high address raises `rspIllegal` and changes no register.
- R5: The `accOp` encoding is 0 = read, 1 = write, 2 = set bits, 3 = clear bits. Set and clear act as a read-modify-write on the addressed half only.
- R6: With `accVirt`=0, an access below the register's level raises `rspIllegal`. The `accPriv` encoding is 0 = user, 1 = supervisor, 3 = machine; encoding 2 is not used.
- R7: With `accVirt`=1, an access to a supervisor-level register (low or high address) raises `rspVirtual`, and an access to a machine-level register raises `rspIllegal`. No trap-control setting takes part in this choice.
- R8: A faulting access returns `rspRdata`=0, changes no register, and never raises both flags at once.
- R9: In the security control register only bits 0, 1, 2, 8 and 9 are writable. All other bits, including the whole high half, read as zero and ignore writes.
- R10: An address outside the map raises `rspIllegal`.
- R11: After reset every register is zero and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access request this cycle |
| accAddr | input | 12 | Register address |
| accOp | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| accWdata | input | XLEN | Write data or bit mask |
| accPriv | input | 2 | Current privilege level |
| accVirt | input | 1 | Virtualization mode bit |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspRdata | output | XLEN | Prior register value (zero on a fault) |
| rspIllegal | output | 1 | Illegal-instruction exception |
| rspVirtual | output | 1 | Virtual-instruction exception |

## Verification
Distinct patterns are written to the high and low halves of the same register, so a write that leaks across the half boundary shows up at once. Set and clear use masks that overlap already-set bits, which separates a true read-modify-write from a plain overwrite.

Privilege tests sweep user, supervisor and machine levels, with the virtualization bit both set and clear, against both supervisor-level and machine-level registers. This separates the two exception kinds. A follow-up read after each faulting write shows that nothing changed.

A second instance with XLEN=64 sees the same access stream. It confirms full-width low access and that high addresses are reserved.

// File: rtl/csr_wide_pkg.sv
package csr_wide_pkg;
  localparam int NUM_REGS = 4;
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int SEC_IDX = 1;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csrOp_e;

  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic [IDX_W-1:0] idx;
    logic             hi;
    csrOp_e           op;
    logic [63:0]      wdata;
  } csrStrobe_t;

  function automatic logic [11:0] lowAddr(input int i);
    case (i)
      0:       return 12'h30A;
      1:       return 12'h747;
      2:       return 12'h60A;
      default: return 12'h605;
    endcase
  endfunction

  // Each high-half alias sits 0x10 above its low-half address.
  function automatic logic [11:0] highAddr(input int i);
    return lowAddr(i) + 12'h010;
  endfunction

  function automatic logic [1:0] regLevel(input logic [IDX_W-1:0] i);
    return (i < 2) ? PRIV_M : PRIV_S;
  endfunction

  function automatic logic [63:0] regMask(input logic [IDX_W-1:0] i);
    return (i == SEC_IDX) ? 64'h0000_0000_0000_0307 : '1;
  endfunction
endpackage

// File: rtl/csr_wide_ctrl.sv
module csr_wide_ctrl
  import csr_wide_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [11:0]     accAddr,
  input  logic [1:0]      accOp,
  input  logic [XLEN-1:0] accWdata,
  input  logic [1:0]      accPriv,
  input  logic            accVirt,
  output csrStrobe_t      stb,
  output logic            rspValid,
  output logic            rspIllegal,
  output logic            rspVirtual
);
  logic             hit;
  logic             hi;
  logic [IDX_W-1:0] idx;
  logic [1:0]       minLvl;
  logic             excIll;
  logic             excVirt;

  // Address decode: low and high aliases of every register.
  always_comb begin
    hit = 1'b0;
    hi  = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (accAddr == lowAddr(i)) begin
        hit = 1'b1;
        hi  = 1'b0;
        idx = IDX_W'(i);
      end
      if (accAddr == highAddr(i)) begin
        hit = 1'b1;
        hi  = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign minLvl = regLevel(idx);

  // Exception classification; order sets priority.
  always_comb begin
    excIll  = 1'b0;
    excVirt = 1'b0;
    if (!hit) begin
      excIll = 1'b1;
    end else if (hi && (XLEN == 64)) begin
      excIll = 1'b1;
    end else if (accVirt) begin
      if (minLvl <= PRIV_S) excVirt = 1'b1;
      else                  excIll  = 1'b1;
    end else if (accPriv < minLvl) begin
      excIll = 1'b1;
    end
  end

  always_comb begin
    stb.rdEn  = accValid && !excIll && !excVirt;
    stb.wrEn  = stb.rdEn && (csrOp_e'(accOp) != OP_READ);
    stb.idx   = idx;
    stb.hi    = hi;
    stb.op    = csrOp_e'(accOp);
    stb.wdata = 64'(accWdata);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspIllegal <= 1'b0;
      rspVirtual <= 1'b0;
    end else begin
      rspValid   <= accValid;
      rspIllegal <= accValid && excIll;
      rspVirtual <= accValid && excVirt;
    end
  end

  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rspIllegal && rspVirtual)); // R8

  AST_EXC_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rspIllegal || rspVirtual) |-> rspValid); // R8

  AST_GUEST_HS_VIRTUAL: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && hit && accVirt && !(hi && XLEN == 64) && minLvl == PRIV_S) |=> rspVirtual); // R7

  generate
    if (XLEN == 64) begin : g_hiReserved
      AST_HI_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
        (accValid && hit && hi) |=> rspIllegal); // R4
    end
  endgenerate
endmodule

// File: rtl/csr_wide_dpath.sv
module csr_wide_dpath
  import csr_wide_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  csrStrobe_t      stb,
  output logic [XLEN-1:0] rdata
);
  localparam logic [63:0] LOW_MASK = (XLEN == 64) ? '1 : 64'h0000_0000_FFFF_FFFF;

  logic [NUM_REGS-1:0][63:0] regs;
  logic [63:0] cur;
  logic [63:0] oldWin;
  logic [63:0] newWin;
  logic [63:0] merged;

  assign cur = regs[stb.idx];

  // The window is the XLEN-wide slice that the access can reach.
  always_comb begin
    oldWin = stb.hi ? {32'b0, cur[63:32]} : (cur & LOW_MASK);
    case (stb.op)
      OP_WRITE: newWin = stb.wdata;
      OP_SET:   newWin = oldWin | stb.wdata;
      OP_CLEAR: newWin = oldWin & ~stb.wdata;
      default:  newWin = oldWin;
    endcase
    merged = stb.hi ? {newWin[31:0], cur[31:0]}
                    : ((cur & ~LOW_MASK) | (newWin & LOW_MASK));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regs  <= '0;
      rdata <= '0;
    end else begin
      if (stb.wrEn) regs[stb.idx] <= merged & regMask(stb.idx);
      rdata <= stb.rdEn ? oldWin[XLEN-1:0] : '0;
    end
  end

  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.hi) |=> regs[$past(stb.idx)][31:0] == $past(cur[31:0])); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(regs)); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regs[SEC_IDX] & ~regMask(IDX_W'(SEC_IDX))) == 64'h0); // R9

  generate
    if (XLEN == 32) begin : g_lowKeepsHi
      AST_LOW_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
        (stb.wrEn && !stb.hi) |=> regs[$past(stb.idx)][63:32] == $past(cur[63:32])); // R2
    end
  endgenerate
endmodule

// File: rtl/csr_wide_bank.sv
module csr_wide_bank
  import csr_wide_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [11:0]     accAddr,
  input  logic [1:0]      accOp,
  input  logic [XLEN-1:0] accWdata,
  input  logic [1:0]      accPriv,
  input  logic            accVirt,
  output logic            rspValid,
  output logic [XLEN-1:0] rspRdata,
  output logic            rspIllegal,
  output logic            rspVirtual
);
  csrStrobe_t stb;

  csr_wide_ctrl #(.XLEN(XLEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accOp(accOp), .accWdata(accWdata), .accPriv(accPriv), .accVirt(accVirt),
    .stb(stb), .rspValid(rspValid), .rspIllegal(rspIllegal), .rspVirtual(rspVirtual)
  );

  csr_wide_dpath #(.XLEN(XLEN)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdata(rspRdata)
  );
endmodule

// File: tb/csr_wide_bank_tb_top.sv
module csr_wide_bank_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [11:0] accAddr = '0;
  logic [1:0] accOp = '0;
  logic [63:0] wd = '0;
  logic [1:0] accPriv = 2'd3;
  logic accVirt = 1'b0;

  logic rv32, il32, vi32, rv64, il64, vi64;
  logic [31:0] rd32;
  logic [63:0] rd64;

  // Response captured by the last access.
  logic [31:0] c32;
  logic [63:0] c64;
  logic cIl32, cVi32, cRv32, cIl64, cVi64;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  csr_wide_bank #(.XLEN(32)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr), .accOp(accOp),
    .accWdata(wd[31:0]), .accPriv(accPriv), .accVirt(accVirt),
    .rspValid(rv32), .rspRdata(rd32), .rspIllegal(il32), .rspVirtual(vi32)
  );

  csr_wide_bank #(.XLEN(64)) dut64_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr), .accOp(accOp),
    .accWdata(wd), .accPriv(accPriv), .accVirt(accVirt),
    .rspValid(rv64), .rspRdata(rd64), .rspIllegal(il64), .rspVirtual(vi64)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic [1:0] op, input logic [63:0] d,
                        input logic [1:0] p, input logic v);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accOp = op; wd = d; accPriv = p; accVirt = v;
    @(negedge clk);
    accValid = 1'b0;
    c32 = rd32; cIl32 = il32; cVi32 = vi32; cRv32 = rv32;
    c64 = rd64; cIl64 = il64; cVi64 = vi64;
  endtask

  task automatic testReset();
    check("R11 rspValid low", {63'b0, rv32}, 64'h0);
    access(12'h605, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R11 low zero", {32'b0, c32}, 64'h0);
    access(12'h615, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R11 high zero", {32'b0, c32}, 64'h0);
    check("R11 valid after access", {63'b0, cRv32}, 64'h1);
  endtask

  task automatic testHalves();
    access(12'h615, 2'd1, 64'hAAAA_BBBB, 2'd3, 1'b0);
    access(12'h605, 2'd1, 64'h1234_5678, 2'd3, 1'b0);
    access(12'h605, 2'd1, 64'h9999_0000, 2'd3, 1'b0);
    check("R1 write returns prior low", {32'b0, c32}, 64'h1234_5678);
    access(12'h615, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R2 high kept after low write", {32'b0, c32}, 64'hAAAA_BBBB);
    access(12'h615, 2'd1, 64'h5555_6666, 2'd3, 1'b0);
    access(12'h605, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R3 low kept after high write", {32'b0, c32}, 64'h9999_0000);
    access(12'h615, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R3 high readback", {32'b0, c32}, 64'h5555_6666);
  endtask

  task automatic testSetClear();
    access(12'h615, 2'd2, 64'h0000_00FF, 2'd3, 1'b0);
    access(12'h615, 2'd3, 64'h5000_000F, 2'd3, 1'b0);
    access(12'h615, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R5 set then clear high", {32'b0, c32}, 64'h0555_66F0);
    access(12'h605, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R5 low untouched", {32'b0, c32}, 64'h9999_0000);
  endtask

  task automatic testPriv();
    access(12'h30A, 2'd1, 64'h1, 2'd1, 1'b0);
    check("R6 S to M reg illegal", {62'b0, cIl32, cVi32}, 64'h2);
    check("R8 fault rdata zero", {32'b0, c32}, 64'h0);
    access(12'h30A, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R8 faulting write left reg", {32'b0, c32}, 64'h0);
    access(12'h60A, 2'd1, 64'hCAFE, 2'd1, 1'b0);
    check("R6 S to S reg ok", {62'b0, cIl32, cVi32}, 64'h0);
    access(12'h60A, 2'd0, 64'h0, 2'd0, 1'b0);
    check("R6 U to S reg illegal", {62'b0, cIl32, cVi32}, 64'h2);
  endtask

  task automatic testVirt();
    access(12'h61A, 2'd1, 64'h77, 2'd1, 1'b1);
    check("R7 guest S high virtual", {62'b0, cIl32, cVi32}, 64'h1);
    access(12'h60A, 2'd0, 64'h0, 2'd0, 1'b1);
    check("R7 guest U low virtual", {62'b0, cIl32, cVi32}, 64'h1);
    access(12'h31A, 2'd0, 64'h0, 2'd1, 1'b1);
    check("R7 guest to M reg illegal", {62'b0, cIl32, cVi32}, 64'h2);
    access(12'h61A, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R8 guest write left high", {32'b0, c32}, 64'h0);
  endtask

  task automatic testSecurity();
    access(12'h747, 2'd1, 64'hFFFF_FFFF, 2'd3, 1'b0);
    access(12'h757, 2'd1, 64'hFFFF_FFFF, 2'd3, 1'b0);
    access(12'h747, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R9 writable bits only", {32'b0, c32}, 64'h307);
    access(12'h757, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R9 high half zero", {32'b0, c32}, 64'h0);
  endtask

  task automatic testUnknown();
    access(12'h123, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R10 unmapped illegal", {62'b0, cIl32, cVi32}, 64'h2);
  endtask

  task automatic testWide();
    access(12'h605, 2'd1, 64'h0123_4567_89AB_CDEF, 2'd3, 1'b0);
    access(12'h605, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R1 XLEN64 full read", c64, 64'h0123_4567_89AB_CDEF);
    check("R2 XLEN64 full write", c64, 64'h0123_4567_89AB_CDEF);
    access(12'h615, 2'd1, 64'hFFFF, 2'd3, 1'b0);
    check("R4 XLEN64 high illegal", {62'b0, cIl64, cVi64}, 64'h2);
    access(12'h605, 2'd0, 64'h0, 2'd3, 1'b0);
    check("R4 XLEN64 state unchanged", c64, 64'h0123_4567_89AB_CDEF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testHalves();
        testSetClear();
        testPriv();
        testVirt();
        testSecurity();
        testUnknown();
        testWide();
      end
      begin
        repeat (5000) @(negedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule